// File: doc/BRIEF.md
# Resource-Aware Round-Robin Thread-Block Dispatcher

This block sits between a queue of pending thread-block launches and an array of streaming multiprocessors. Each cycle it looks at the request at the head of the queue, which gives the block's thread count, shared-memory bytes and register count. It picks one multiprocessor that can hold the block. The search is round-robin, but a multiprocessor that lacks a free block slot, enough free threads, enough free shared memory or enough free registers is skipped rather than granted.

The dispatcher keeps an occupancy record for every multiprocessor. A dispatch adds the block's needs to the chosen target. A completion report names a multiprocessor and returns the finished block's needs to it. A completion takes effect in its own cycle, so a request in that same cycle can already use the freed room. A request larger than a whole multiprocessor could ever hold is refused with an error flag, so it does not stall the queue.

The grant and the refusal are combinational on the current request, so the queue can pop in the cycle it sees either strobe. The default configuration serves 30 multiprocessors, arranged as 10 clusters of 3. Each has 8 block slots, 1024 thread slots, 16384 bytes of shared memory and 16384 registers.

Top module: `blkd_dispatch_top`

## Requirements
- R1: After reset every multiprocessor is fully free and the search pointer is at multiprocessor 0. With no request present, `disp_valid` and `rej_err` are both 0.
- R2: When `req_valid` is 1 and at least one multiprocessor is eligible, `disp_valid` is 1 in that same cycle and `disp_sm` gives the chosen index (0 to NUM_SM-1). The strobe lasts one cycle for each request consumed.
- R3: A multiprocessor is eligible only if all four of these hold: fewer than 8 blocks are resident; resident threads plus requested threads are at most 1024; resident shared memory plus requested bytes is at most 16384; resident registers plus requested registers are at most 16384. A request that exactly reaches a limit fits.
- R4: The search starts at the pointer and goes upward through the indices, wrapping from NUM_SM-1 to 0. The first eligible multiprocessor in that order is chosen, and ineligible ones are skipped.
- R5: After a dispatch, the pointer moves to the index after the chosen one, with NUM_SM-1 followed by 0.
- R6: If no multiprocessor is eligible, there is no strobe and the pointer keeps its value, so the request waits.
- R7: A dispatch adds one block and the request's threads, shared memory and registers to the chosen multiprocessor's occupancy.
- R8: When `cpl_valid` is 1, one block and the reported threads, bytes and registers are freed on `cpl_sm`. A request in the same cycle already sees that room as free. A completion alone causes no strobe.
- R9: A request whose threads exceed 1024, bytes exceed 16384 or registers exceed 16384 raises `rej_err` for that cycle instead of `disp_valid`. It changes no occupancy and does not move the pointer.
- R10: `disp_valid` and `rej_err` are never 1 together, and neither is 1 while `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A launch request is at the queue head |
| req_thr | input | 11 | Threads the block needs |
| req_smem | input | 15 | Shared-memory bytes the block needs |
| req_regs | input | 15 | Registers the block needs |
| cpl_valid | input | 1 | A block has finished |
| cpl_sm | input | 5 | Multiprocessor the finished block ran on |
| cpl_thr | input | 11 | Threads freed by the finished block |
| cpl_smem | input | 15 | Shared-memory bytes freed |
| cpl_regs | input | 15 | Registers freed |
| disp_valid | output | 1 | Request granted this cycle (queue pops) |
| disp_sm | output | 5 | Index of the granted multiprocessor |
| rej_err | output | 1 | Request can never fit; refused (queue pops) |

## Verification
The assertions assume that every completion report is truthful. It names an index below NUM_SM, on which a block with exactly those needs is still resident, so occupancy never goes below zero. They also assume that a waiting request keeps its fields stable until it is granted or refused. The bench meets both assumptions by construction. It reports completions only for blocks its own model recorded as dispatched to that multiprocessor, it repeats a stalled request unchanged, and it drives every input at the falling edge.

// File: rtl/blkd_pkg.sv
package blkd_pkg;
    // Capacity of one multiprocessor and the array size
    localparam int SM_COUNT = 30;
    localparam int BLK_CAP  = 8;
    localparam int THR_CAP  = 1024;
    localparam int SMEM_CAP = 16384;
    localparam int REG_CAP  = 16384;

    // Field widths able to hold zero up to the full capacity
    localparam int BLK_W  = $clog2(BLK_CAP + 1);
    localparam int THR_W  = $clog2(THR_CAP + 1);
    localparam int SMEM_W = $clog2(SMEM_CAP + 1);
    localparam int REG_W  = $clog2(REG_CAP + 1);

    // Resources currently held on one multiprocessor
    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [THR_W-1:0]  thr;
        logic [SMEM_W-1:0] smem;
        logic [REG_W-1:0]  regs;
    } sm_use_t;
endpackage

// File: rtl/blkd_sm_fit.sv
// Decides whether one multiprocessor has room for the pending block.
module blkd_sm_fit
    import blkd_pkg::*;
#(
    parameter int MAX_BLK  = BLK_CAP,
    parameter int MAX_THR  = THR_CAP,
    parameter int MAX_SMEM = SMEM_CAP,
    parameter int MAX_REG  = REG_CAP
) (
    input  sm_use_t           used,
    input  logic [THR_W-1:0]  need_thr,
    input  logic [SMEM_W-1:0] need_smem,
    input  logic [REG_W-1:0]  need_regs,
    output logic              fits
);
    localparam logic [BLK_W-1:0]  BLK_LIM  = BLK_W'(MAX_BLK);
    localparam logic [THR_W:0]    THR_LIM  = (THR_W + 1)'(MAX_THR);
    localparam logic [SMEM_W:0]   SMEM_LIM = (SMEM_W + 1)'(MAX_SMEM);
    localparam logic [REG_W:0]    REG_LIM  = (REG_W + 1)'(MAX_REG);

    logic [THR_W:0]  thr_sum;
    logic [SMEM_W:0] smem_sum;
    logic [REG_W:0]  reg_sum;

    always_comb begin
        thr_sum  = {1'b0, used.thr}  + {1'b0, need_thr};
        smem_sum = {1'b0, used.smem} + {1'b0, need_smem};
        reg_sum  = {1'b0, used.regs} + {1'b0, need_regs};
        fits     = (used.blk < BLK_LIM) && (thr_sum <= THR_LIM) &&
                   (smem_sum <= SMEM_LIM) && (reg_sum <= REG_LIM);
    end
endmodule

// File: rtl/blkd_rr_pick.sv
// Rotating first-one finder: the lowest offset from start with elig set wins.
module blkd_rr_pick #(
    parameter int N     = 30,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     elig,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = start;
        // Walk from the farthest offset down so the nearest eligible one is kept
        for (int k = N - 1; k >= 0; k--) begin
            idx = int'(start) + k;
            if (idx >= N) idx = idx - N;
            if (elig[idx]) begin
                found = 1'b1;
                pick  = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/blkd_dispatch_top.sv
module blkd_dispatch_top
    import blkd_pkg::*;
#(
    parameter int NUM_SM   = SM_COUNT,
    parameter int MAX_BLK  = BLK_CAP,
    parameter int MAX_THR  = THR_CAP,
    parameter int MAX_SMEM = SMEM_CAP,
    parameter int MAX_REG  = REG_CAP,
    localparam int IDX_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [THR_W-1:0]  req_thr,
    input  logic [SMEM_W-1:0] req_smem,
    input  logic [REG_W-1:0]  req_regs,
    input  logic              cpl_valid,
    input  logic [IDX_W-1:0]  cpl_sm,
    input  logic [THR_W-1:0]  cpl_thr,
    input  logic [SMEM_W-1:0] cpl_smem,
    input  logic [REG_W-1:0]  cpl_regs,
    output logic              disp_valid,
    output logic [IDX_W-1:0]  disp_sm,
    output logic              rej_err
);
    localparam logic [THR_W-1:0]  THR_MAXV  = THR_W'(MAX_THR);
    localparam logic [SMEM_W-1:0] SMEM_MAXV = SMEM_W'(MAX_SMEM);
    localparam logic [REG_W-1:0]  REG_MAXV  = REG_W'(MAX_REG);
    localparam logic [IDX_W-1:0]  LAST_SM   = IDX_W'(NUM_SM - 1);

    typedef struct packed {
        sm_use_t [NUM_SM-1:0] occ;
        logic [IDX_W-1:0]     ptr;
    } dstate_t;

    dstate_t              st_q, st_d;
    sm_use_t [NUM_SM-1:0] avail_occ;
    logic [NUM_SM-1:0]    fit_vec;
    logic                 oversize;
    logic                 any_fit;
    logic [IDX_W-1:0]     pick;

    // Completion bypass: free the reported block before the fit test
    always_comb begin
        for (int i = 0; i < NUM_SM; i++) begin
            avail_occ[i] = st_q.occ[i];
            if (cpl_valid && (cpl_sm == IDX_W'(i))) begin
                avail_occ[i].blk  = st_q.occ[i].blk  - BLK_W'(1);
                avail_occ[i].thr  = st_q.occ[i].thr  - cpl_thr;
                avail_occ[i].smem = st_q.occ[i].smem - cpl_smem;
                avail_occ[i].regs = st_q.occ[i].regs - cpl_regs;
            end
        end
    end

    // One fit test per multiprocessor
    for (genvar g = 0; g < NUM_SM; g++) begin : g_fit
        blkd_sm_fit #(
            .MAX_BLK (MAX_BLK),
            .MAX_THR (MAX_THR),
            .MAX_SMEM(MAX_SMEM),
            .MAX_REG (MAX_REG)
        ) u_fit (
            .used     (avail_occ[g]),
            .need_thr (req_thr),
            .need_smem(req_smem),
            .need_regs(req_regs),
            .fits     (fit_vec[g])
        );
    end

    blkd_rr_pick #(
        .N    (NUM_SM),
        .IDX_W(IDX_W)
    ) u_pick (
        .elig (fit_vec),
        .start(st_q.ptr),
        .found(any_fit),
        .pick (pick)
    );

    // A block larger than an empty multiprocessor can never be placed
    assign oversize   = (req_thr > THR_MAXV) || (req_smem > SMEM_MAXV) ||
                        (req_regs > REG_MAXV);
    assign disp_valid = req_valid && !oversize && any_fit;
    assign rej_err    = req_valid && oversize;
    assign disp_sm    = pick;

    // Next state: charge the chosen target and advance the pointer
    always_comb begin
        st_d     = st_q;
        st_d.occ = avail_occ;
        if (disp_valid) begin
            st_d.occ[pick].blk  = avail_occ[pick].blk  + BLK_W'(1);
            st_d.occ[pick].thr  = avail_occ[pick].thr  + req_thr;
            st_d.occ[pick].smem = avail_occ[pick].smem + req_smem;
            st_d.occ[pick].regs = avail_occ[pick].regs + req_regs;
            st_d.ptr            = (pick == LAST_SM) ? '0 : pick + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/blkd_dispatch_chk.sv
module blkd_dispatch_chk
    import blkd_pkg::*;
#(
    parameter int NUM_SM   = SM_COUNT,
    parameter int MAX_BLK  = BLK_CAP,
    parameter int MAX_THR  = THR_CAP,
    parameter int MAX_SMEM = SMEM_CAP,
    parameter int MAX_REG  = REG_CAP,
    parameter int IDX_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [THR_W-1:0]     req_thr,
    input logic [SMEM_W-1:0]    req_smem,
    input logic [REG_W-1:0]     req_regs,
    input logic                 disp_valid,
    input logic [IDX_W-1:0]     disp_sm,
    input logic                 rej_err,
    input sm_use_t [NUM_SM-1:0] occ_q,
    input logic [IDX_W-1:0]     ptr_q
);
    logic over_any;

    always_comb begin
        over_any = 1'b0;
        for (int i = 0; i < NUM_SM; i++) begin
            if ((int'(occ_q[i].blk) > MAX_BLK) || (int'(occ_q[i].thr) > MAX_THR) ||
                (int'(occ_q[i].smem) > MAX_SMEM) || (int'(occ_q[i].regs) > MAX_REG))
                over_any = 1'b1;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) !over_any);

    // R10
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_valid && rej_err));

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid || rej_err) |-> req_valid);

    // R2
    sm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (int'(disp_sm) < NUM_SM));

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> (ptr_q == ((int'($past(disp_sm)) == NUM_SM - 1) ?
                                   '0 : $past(disp_sm) + IDX_W'(1))));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |=> $stable(ptr_q));

    // R9
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_err |-> ((int'(req_thr) > MAX_THR) || (int'(req_smem) > MAX_SMEM) ||
                     (int'(req_regs) > MAX_REG)));
endmodule

bind blkd_dispatch_top blkd_dispatch_chk #(
    .NUM_SM  (NUM_SM),
    .MAX_BLK (MAX_BLK),
    .MAX_THR (MAX_THR),
    .MAX_SMEM(MAX_SMEM),
    .MAX_REG (MAX_REG),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_thr   (req_thr),
    .req_smem  (req_smem),
    .req_regs  (req_regs),
    .disp_valid(disp_valid),
    .disp_sm   (disp_sm),
    .rej_err   (rej_err),
    .occ_q     (st_q.occ),
    .ptr_q     (st_q.ptr)
);

// File: tb/tb_blkd_dispatch_top.sv
module tb_blkd_dispatch_top;
    import blkd_pkg::*;
    localparam int N  = SM_COUNT;
    localparam int IW = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [THR_W-1:0]  req_thr = '0;
    logic [SMEM_W-1:0] req_smem = '0;
    logic [REG_W-1:0]  req_regs = '0;
    logic              cpl_valid = 1'b0;
    logic [IW-1:0]     cpl_sm = '0;
    logic [THR_W-1:0]  cpl_thr = '0;
    logic [SMEM_W-1:0] cpl_smem = '0;
    logic [REG_W-1:0]  cpl_regs = '0;
    logic              disp_valid;
    logic [IW-1:0]     disp_sm;
    logic              rej_err;

    always #2 clk = ~clk;

    blkd_dispatch_top dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_thr(req_thr), .req_smem(req_smem), .req_regs(req_regs),
        .cpl_valid(cpl_valid), .cpl_sm(cpl_sm), .cpl_thr(cpl_thr),
        .cpl_smem(cpl_smem), .cpl_regs(cpl_regs),
        .disp_valid(disp_valid), .disp_sm(disp_sm), .rej_err(rej_err)
    );

    // kind: 0 = no strobe, 1 = dispatch, 2 = reject
    typedef struct {
        int    kind;
        int    sm;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference occupancy and pointer, built from the requirements
    int mb[N], mt[N], ms[N], mr[N];
    int mptr;

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            mb[i] = 0; mt[i] = 0; ms[i] = 0; mr[i] = 0;
        end
        mptr = 0;
    endtask

    // One cycle of stimulus; pushes the expected outcome of a request
    task automatic step(input bit rv, input int t, input int s, input int r,
                        input bit cv, input int csm, input int ct, input int cs,
                        input int cr, input string tag);
        exp_t e;
        int   idx;
        @(negedge clk);
        req_valid = rv; req_thr = THR_W'(t); req_smem = SMEM_W'(s); req_regs = REG_W'(r);
        cpl_valid = cv; cpl_sm = IW'(csm); cpl_thr = THR_W'(ct);
        cpl_smem = SMEM_W'(cs); cpl_regs = REG_W'(cr);
        if (cv) begin
            mb[csm] -= 1; mt[csm] -= ct; ms[csm] -= cs; mr[csm] -= cr;
        end
        if (rv) begin
            e.tag = tag; e.sm = -1; e.kind = 0;
            if (t > THR_CAP || s > SMEM_CAP || r > REG_CAP) begin
                e.kind = 2;
            end else begin
                for (int k = 0; k < N; k++) begin
                    idx = (mptr + k) % N;
                    if (e.kind == 0 && mb[idx] < BLK_CAP && mt[idx] + t <= THR_CAP &&
                        ms[idx] + s <= SMEM_CAP && mr[idx] + r <= REG_CAP) begin
                        e.kind = 1; e.sm = idx;
                    end
                end
                if (e.kind == 1) begin
                    mb[e.sm] += 1; mt[e.sm] += t; ms[e.sm] += s; mr[e.sm] += r;
                    mptr = (e.sm + 1) % N;
                end
            end
            exp_q.push_back(e);
        end
    endtask

    task automatic req(input int t, input int s, input int r, input string tag);
        step(1'b1, t, s, r, 1'b0, 0, 0, 0, 0, tag);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
        repeat (2) @(negedge clk);
        model_clear();
        #1;
        checks++;
        if (disp_valid !== 1'b0 || rej_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: strobes in reset got disp=%b rej=%b expected 0 0",
                     disp_valid, rej_err);
        end
        rst_n = 1'b1;
    endtask

    // Monitor: compares what the design shows against the next expectation
    initial begin
        exp_t e;
        int   got;
        forever begin
            @(negedge clk);
            #1;
            got = disp_valid ? 1 : (rej_err ? 2 : 0);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (got != e.kind || (e.kind == 1 && int'(disp_sm) != e.sm)) begin
                    errors++;
                    $display("FAIL %s: got kind=%0d sm=%0d expected kind=%0d sm=%0d",
                             e.tag, got, disp_sm, e.kind, e.sm);
                end
            end else if (rst_n && got != 0) begin
                checks++;
                errors++;
                $display("FAIL R10: strobe without request got kind=%0d expected 0", got);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();
        idle();
        idle();

        // R1 / R4 / R5: rotation from index 0, wrap past the last
        for (int i = 0; i <= N; i++) req(32, 0, 0, "R4");

        // R7 / R6 / R5 / R8: fill all block slots, then stall and release
        do_reset();
        for (int i = 0; i < N * BLK_CAP; i++) req(1, 0, 0, "R7");
        for (int i = 0; i < 3; i++) req(1, 0, 0, "R6");
        step(1'b0, 0, 0, 0, 1'b1, 3, 1, 0, 0, "R8");
        step(1'b0, 0, 0, 0, 1'b1, 25, 1, 0, 0, "R8");
        req(1, 0, 0, "R6");
        req(1, 0, 0, "R5");
        req(1, 0, 0, "R6");
        step(1'b1, 1, 0, 0, 1'b1, 9, 1, 0, 0, "R8");

        // R3 / R4: exact-limit blocks, then a skip over three full targets
        do_reset();
        req(1, SMEM_CAP, 0, "R3");
        req(THR_CAP, 0, 0, "R3");
        req(1, 0, REG_CAP, "R3");
        for (int i = 3; i < N; i++) req(1, 0, 0, "R2");
        req(1, 1, 1, "R4");

        // R9: oversize refusals leave the pointer and occupancy alone
        req(THR_CAP + 1, 0, 0, "R9");
        req(1, SMEM_CAP + 1, 0, "R9");
        step(1'b1, 1, 0, REG_CAP + 1, 1'b1, 0, 1, SMEM_CAP, 0, "R9");
        req(1, 0, 0, "R9");
        req(1, SMEM_CAP, 0, "R9");

        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d expected outcomes unobserved, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule